// File: doc/BRIEF.md
# Bit-Serial Distributed Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that uses no multipliers. It keeps the most recent `NTAPS` input samples in a delay line. For each new sample it forms the filter output one bit plane at a time. On every clock it gathers the same bit position from all taps into an `NTAPS`-bit word. That word addresses a table that holds every possible sum of coefficients. The table value is folded into an accumulator with the correct power-of-two weight. The table has `2^NTAPS` entries and is computed from the coefficient parameter at elaboration.

Samples are two's complement. They arrive on a valid/ready handshake, and one is accepted only while the filter is idle. A sample takes `XW` processing cycles, one per bit plane, starting with the least significant bit. The table term for the sign bit is subtracted rather than added. The accumulator shifts right by one position per bit plane and keeps the bits it shifts out in a low extension register. As a result the output carries the full precision of the sum of products. The output is flagged valid for a single clock and holds its value until the next result replaces it.

Top module: `da_fir_filter`

## Requirements
- R1: For each accepted sample, `out_data_o` equals the exact sum over j of `h[j]·x[n−j]`, where `h[j]` is the coefficient in bits `[j*CW +: CW]` of `COEFS` and `x[n−j]` is the sample accepted j handshakes earlier. The result is a signed `XW+CW+clog2(NTAPS)`-bit value.
- R2: Inputs and coefficients are two's complement. Samples at the full-scale extremes −2^(XW−1) and 2^(XW−1)−1 give exact results.
- R3: A sample is accepted on a rising clock edge where `in_valid_o` and `in_ready_o` are both high. After the accepting edge, `in_ready_o` stays low for exactly `XW` clock cycles.
- R4: `out_valid_o` is high for exactly one clock cycle, beginning `XW` rising edges after the accepting edge. At all other times it is low.
- R5: While `in_ready_o` is low, `in_valid_i` and `in_data_i` have no effect. Neither the current result nor any later result reflects them.
- R6: Each accepted sample moves the delay line by one tap, and a sample drops out after `NTAPS` further acceptances. A unit impulse followed by zeros therefore produces `h[0]`, `h[1]`, … `h[NTAPS−1]`, then zero.
- R7: An asynchronous low on `rst_ni` clears the delay line, the accumulator, the bit counter and the output. During reset `in_ready_o` is high and `out_valid_o` is low. This also applies to a reset that arrives in the middle of processing.
- R8: `out_data_o` changes only in a cycle where `out_valid_o` is high, and it holds the last result otherwise.
- R9: `in_ready_o` is high in the same cycle that `out_valid_o` is high. A new sample can therefore be accepted on the very next edge, giving `XW+1` cycles per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample offered |
| in_ready_o | output | 1 | Filter idle, sample can be taken |
| in_data_i | input | XW | Two's complement input sample |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | XW+CW+clog2(NTAPS) | Signed full-precision filter output |

## Verification
The assertions check on every cycle the structural timing. They cover the drop of ready after an accepting edge, the one-cycle output strobe and its fixed distance from acceptance, the bit counter range, and the load, shift and hold of the delay line. They also check that the output register changes only under its strobe. The arithmetic itself can only be shown by the bench scenarios. These compare every result against a directly computed sum of products for impulse, full-scale, alternating-extreme and random sample streams. The bench scenarios also cover sample loss or corruption from inputs offered while busy, back-to-back acceptance, and recovery from a reset in mid-computation.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } da_state_e;

  typedef struct packed {
    logic start;  // sample accepted this cycle
    logic step;   // one bit plane processed this cycle
    logic last;   // bit plane is the sign bit
  } da_ctl_t;

endpackage

// File: rtl/da_fir_ctrl.sv
module da_fir_ctrl
  import da_fir_pkg::*;
#(
  parameter int XW   = 8,
  localparam int CNTW = (XW > 1) ? $clog2(XW) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  output da_ctl_t         ctl_o,
  output logic [CNTW-1:0] bit_idx_o
);

  localparam logic [CNTW-1:0] LAST_BIT = CNTW'(XW - 1);

  da_state_e       state_q;
  logic [CNTW-1:0] cnt_q;

  assign in_ready_o  = (state_q == ST_IDLE);
  assign ctl_o.start = in_ready_o && in_valid_i;
  assign ctl_o.step  = (state_q == ST_RUN);
  assign ctl_o.last  = ctl_o.step && (cnt_q == LAST_BIT);
  assign bit_idx_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ctl_o.start) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (ctl_o.last) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  accept_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q <= LAST_BIT));

endmodule

// File: rtl/da_fir_delay_line.sv
module da_fir_delay_line #(
  parameter int NTAPS = 8,
  parameter int XW    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  logic [XW-1:0]         sample_i,
  output logic [NTAPS*XW-1:0]   taps_o
);

  logic [NTAPS*XW-1:0] taps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taps_q <= '0;
    end else if (push_i) begin
      if (NTAPS > 1) begin
        taps_q <= {taps_q[(NTAPS-1)*XW-1:0], sample_i};
      end else begin
        taps_q <= sample_i;
      end
    end
  end

  assign taps_o = taps_q;

  // R6
  tap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (taps_q[XW-1:0] == $past(sample_i)));

  generate
    if (NTAPS > 1) begin : g_shift_chk
      // R6
      tap_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |=> (taps_q[NTAPS*XW-1:XW] == $past(taps_q[(NTAPS-1)*XW-1:0])));
    end
  endgenerate

  // R5
  tap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(taps_q));

endmodule

// File: rtl/da_fir_lut.sv
module da_fir_lut #(
  parameter int                   NTAPS = 8,
  parameter int                   CW    = 16,
  parameter logic [NTAPS*CW-1:0]  COEFS = '0,
  localparam int                  TW    = CW + $clog2(NTAPS) + 1,
  localparam int                  DEPTH = 1 << NTAPS
) (
  input  logic [NTAPS-1:0]        addr_i,
  output logic signed [TW-1:0]    sum_o
);

  // Sum of the coefficients selected by the set bits of sel.
  function automatic logic signed [TW-1:0] coef_sum(input logic [NTAPS-1:0] sel);
    logic signed [TW-1:0] acc;
    logic signed [CW-1:0] c;
    acc = '0;
    for (int j = 0; j < NTAPS; j++) begin
      c = COEFS[j*CW +: CW];
      if (sel[j]) acc = acc + TW'(c);
    end
    return acc;
  endfunction

  logic signed [TW-1:0] rom [DEPTH];

  generate
    for (genvar a = 0; a < DEPTH; a++) begin : g_rom
      localparam logic signed [TW-1:0] ENTRY = coef_sum(NTAPS'(a));
      assign rom[a] = ENTRY;
    end
  endgenerate

  assign sum_o = rom[addr_i];

endmodule

// File: rtl/da_fir_accum.sv
module da_fir_accum #(
  parameter int  NTAPS = 8,
  parameter int  XW    = 8,
  parameter int  CW    = 16,
  localparam int TW    = CW + $clog2(NTAPS) + 1,
  localparam int HW    = TW + 1,
  localparam int YW    = XW + CW + $clog2(NTAPS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  step_i,
  input  logic                  last_i,
  input  logic signed [TW-1:0]  term_i,
  output logic                  out_valid_o,
  output logic signed [YW-1:0]  out_data_o
);

  logic signed [HW-1:0] hi_q;
  logic        [XW-1:0] lo_q;
  logic signed [HW-1:0] addend;
  logic signed [HW-1:0] sum;
  logic signed [HW-1:0] hi_next;
  logic        [XW-1:0] lo_next;
  logic                 vld_q;
  logic signed [YW-1:0] y_q;

  always_comb begin
    // sign-bit plane carries negative weight
    addend  = last_i ? -HW'(term_i) : HW'(term_i);
    sum     = hi_q + addend;
    hi_next = sum >>> 1;
    if (XW > 1) lo_next = {sum[0], lo_q[XW-1:1]};
    else        lo_next = sum[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      vld_q <= 1'b0;
      y_q   <= '0;
    end else begin
      vld_q <= last_i;
      if (start_i) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (step_i) begin
        hi_q <= hi_next;
        lo_q <= lo_next;
      end
      if (last_i) y_q <= YW'({hi_next, lo_next});
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = y_q;

  // R4
  out_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_data_o) |-> out_valid_o);

endmodule

// File: rtl/da_fir_filter.sv
module da_fir_filter
  import da_fir_pkg::*;
#(
  parameter int                  NTAPS = 8,
  parameter int                  XW    = 8,
  parameter int                  CW    = 16,
  parameter logic [NTAPS*CW-1:0] COEFS = {16'h00FA, 16'hFFFF, 16'h004D, 16'h1000,
                                          16'h8000, 16'h7FFF, 16'hF830, 16'h03E8},
  localparam int                 TW    = CW + $clog2(NTAPS) + 1,
  localparam int                 YW    = XW + CW + $clog2(NTAPS),
  localparam int                 CNTW  = (XW > 1) ? $clog2(XW) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [XW-1:0]        in_data_i,
  output logic                 out_valid_o,
  output logic signed [YW-1:0] out_data_o
);

  da_ctl_t              ctl;
  logic [CNTW-1:0]      bit_idx;
  logic [NTAPS*XW-1:0]  taps;
  logic [NTAPS-1:0]     plane;
  logic signed [TW-1:0] term;

  da_fir_ctrl #(.XW(XW)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .ctl_o      (ctl),
    .bit_idx_o  (bit_idx)
  );

  da_fir_delay_line #(.NTAPS(NTAPS), .XW(XW)) i_delay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (ctl.start),
    .sample_i (in_data_i),
    .taps_o   (taps)
  );

  // bit plane: same bit position taken from every tap
  generate
    for (genvar j = 0; j < NTAPS; j++) begin : g_plane
      assign plane[j] = taps[j*XW + int'(bit_idx)];
    end
  endgenerate

  da_fir_lut #(.NTAPS(NTAPS), .CW(CW), .COEFS(COEFS)) i_lut (
    .addr_i (plane),
    .sum_o  (term)
  );

  da_fir_accum #(.NTAPS(NTAPS), .XW(XW), .CW(CW)) i_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (ctl.start),
    .step_i      (ctl.step),
    .last_i      (ctl.last),
    .term_i      (term),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  // latency monitor: edges since the last accepted sample
  localparam int LW = $clog2(XW + 2) + 1;
  logic [LW-1:0] since_acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_acc_q <= LW'(XW + 1);
    else if (in_valid_i && in_ready_o) since_acc_q <= '0;
    else if (since_acc_q != LW'(XW + 1)) since_acc_q <= since_acc_q + 1'b1;
  end

  // R4
  out_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (since_acc_q == LW'(XW)));

  // R9
  ready_on_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> in_ready_o);

endmodule

// File: tb/test_da_fir_filter.sv
module test_da_fir_filter;

  localparam int NT = 8;
  localparam int XW = 8;
  localparam int CW = 16;
  localparam int YW = XW + CW + $clog2(NT);

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 in_valid_i = 1'b0;
  logic [XW-1:0]        in_data_i = '0;
  logic                 in_ready_o;
  logic                 out_valid_o;
  logic signed [YW-1:0] out_data_o;

  always #10 clk_i = ~clk_i;

  da_fir_filter i_da_fir_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  int     checks = 0;
  int     errors = 0;
  bit     finished = 1'b0;
  int     coef [NT] = '{1000, -2000, 32767, -32768, 4096, 77, -1, 250};
  longint hist [NT];
  longint last_y = 0;

  function automatic longint model_out();
    longint s = 0;
    for (int j = 0; j < NT; j++) s += longint'(coef[j]) * hist[j];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int j = 0; j < NT; j++) hist[j] = 0;
  endtask

  task automatic push_hist(input int x);
    for (int j = NT - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = x;
  endtask

  // Entered at a negedge with in_ready high; returns at the result negedge.
  task automatic run_sample(input int x, input bit junk, input string req);
    longint act;
    in_valid_i = 1'b1;
    in_data_i  = x[XW-1:0];
    for (int k = 1; k <= XW; k++) begin
      @(negedge clk_i);
      in_valid_i = junk;
      in_data_i  = XW'($urandom);
      chk(in_ready_o == 1'b0, "R3", "ready while busy", longint'(in_ready_o), 0);
      chk(out_valid_o == 1'b0, "R4", "early valid", longint'(out_valid_o), 0);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    push_hist(x);
    act = out_data_o;
    chk(out_valid_o == 1'b1, "R4", "valid strobe", longint'(out_valid_o), 1);
    chk(act == model_out(), junk ? "R5" : req, "result", act, model_out());
    chk(in_ready_o == 1'b1, "R9", "ready with result", longint'(in_ready_o), 1);
    last_y = act;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      chk(out_valid_o == 1'b0, "R4", "strobe width", longint'(out_valid_o), 0);
      chk(longint'(out_data_o) == last_y, "R8", "held output", longint'(out_data_o), last_y);
    end
  endtask

  initial begin
    logic signed [XW-1:0] r;
    void'($urandom(32'd4711));
    clear_hist();
    repeat (3) @(negedge clk_i);
    // R7 reset state
    chk(in_ready_o == 1'b1, "R7", "ready in reset", longint'(in_ready_o), 1);
    chk(out_valid_o == 1'b0, "R7", "valid in reset", longint'(out_valid_o), 0);
    chk(out_data_o == '0, "R7", "output in reset", longint'(out_data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 impulse response
    run_sample(1, 1'b0, "R6");
    for (int k = 0; k < NT; k++) run_sample(0, 1'b0, "R6");
    idle(3);

    // R2 full-scale extremes
    for (int k = 0; k < NT; k++) run_sample(127, 1'b0, "R2");
    for (int k = 0; k < NT; k++) run_sample(-128, 1'b0, "R2");
    for (int k = 0; k < 2 * NT; k++) run_sample((k % 2) ? 127 : -128, 1'b0, "R2");
    idle(2);

    // R5 inputs offered while busy
    for (int k = 0; k < 12; k++) begin
      r = XW'($urandom);
      run_sample(int'(r), 1'b1, "R5");
    end
    idle(4);

    // R7 reset during processing
    in_valid_i = 1'b1;
    in_data_i  = 8'd55;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(in_ready_o == 1'b1, "R7", "ready after mid reset", longint'(in_ready_o), 1);
    chk(out_valid_o == 1'b0, "R7", "valid after mid reset", longint'(out_valid_o), 0);
    chk(out_data_o == '0, "R7", "output after mid reset", longint'(out_data_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    clear_hist();
    last_y = 0;
    @(negedge clk_i);
    run_sample(-128, 1'b0, "R7");
    run_sample(100, 1'b0, "R7");

    // R1 random stream, back-to-back and with gaps
    for (int k = 0; k < 200; k++) begin
      r = XW'($urandom);
      run_sample(int'(r), ($urandom % 4) == 0, "R1");
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL R4 watchdog: actual %0d cycles expected completion", 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule